// File: doc/BRIEF.md
# Peak Detector Reset and Hold Sequencer

This block times the reset and hold controls for a bank of analog peak-hold channels. Each channel has a discriminator flag that is high while a pulse is present. When any flag falls, the pulse has ended. The block then waits a fixed settling delay and clears every detector with one common reset pulse. The hold output rises before the reset starts and stays high for a short extension after it ends, so the reset is never applied to an unheld detector.

A converter that wants to digitize the stored peaks raises a hold request. If the request appears during the settling delay, the reset is deferred. The detectors stay held until the request drops, and the reset runs then. An optional early mode lets a strobe from the converter start the reset while the request is still high, which shortens the dead time. All inputs pass through two-stage synchronizers. Falls that arrive while a sequence is running are ignored, and the block rearms only after the hold extension has finished. All durations are parameters counted in clock cycles, and their defaults are derived from the clock frequency.

Top module: `pk_reset_seq`

## Requirements
- R1: A high-to-low transition on any one of the NUM_CH flag inputs starts a sequence, and busy rises on the third rising clock edge after the flag changes. A low-to-high transition alone starts nothing.
- R2: det_hold rises DELAY_CYC cycles after busy rises. When no hold request was seen during the delay, det_reset rises exactly one cycle after det_hold.
- R3: Every det_reset pulse lasts exactly RESET_CYC cycles.
- R4: det_hold stays high for exactly EXT_CYC cycles after det_reset falls. det_reset is never high while det_hold is low.
- R5: If conv_hold is seen high while the delay runs, no reset is issued at the end of the delay. det_hold stays high, and det_reset rises on the third rising edge after conv_hold falls.
- R6: With EARLY_EN set, a rising conv_early while a deferred reset is waiting starts det_reset on the third rising edge after the strobe rises. A conv_hold that falls later has no effect.
- R7: Flag falls that arrive while busy is high are ignored and do not change any timing. After busy falls, the block stays idle until a new fall occurs.
- R8: A synchronous active-high rst forces det_reset, det_hold and busy low on the next clock edge, from any point of a sequence.
- R9: busy is high from the triggering edge until the hold extension ends, and it falls on the same edge as det_hold. A conv_hold toggled while idle leaves all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_flag | input | NUM_CH | Discriminator flags, one per channel (asynchronous) |
| conv_hold | input | 1 | Conversion hold request from the converter (asynchronous) |
| conv_early | input | 1 | Early reset strobe from the converter (asynchronous), used when EARLY_EN is set |
| det_reset | output | 1 | Common detector reset pulse |
| det_hold | output | 1 | Detector hold, brackets every reset |
| busy | output | 1 | High while a sequence is in progress |

## Verification
Plain triggers on randomly chosen channels check the undisturbed delay, reset and extension timing, and show that any channel can trigger. Deferred runs raise the hold request at random points inside the delay and hold it for random lengths, which separates a reset keyed to the end of the delay from one keyed to the hold request falling. Early-strobe runs show that the strobe, and not the request, ends the wait. Extra falls on other channels during a run, hold toggles while idle, and a reset in the middle of a pulse check that stray input is ignored and that the block returns to a clean idle state.

// File: rtl/pkseq_pkg.sv
package pkseq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_DELAY,
    SQ_WAIT,
    SQ_GUARD,
    SQ_RST,
    SQ_EXT
  } sq_state_t;

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pkseq_sync.sv
module pkseq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign d_out = stg[STAGES-1];

endmodule

// File: rtl/pkseq_ctrl.sv
module pkseq_ctrl
  import pkseq_pkg::*;
#(
  parameter int DELAY_CYC = 100,
  parameter int RESET_CYC = 300,
  parameter int EXT_CYC   = 25,
  parameter bit EARLY_EN  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic hold_req,
  input  logic early_rise,
  output logic det_reset,
  output logic det_hold,
  output logic busy
);

  localparam int CNT_MAX = max3(DELAY_CYC, RESET_CYC, EXT_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RESET_CYC - 1);
  localparam logic [CNT_W-1:0] EXT_LAST = CNT_W'(EXT_CYC - 1);

  sq_state_t        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             defer_q, defer_d;
  logic             early_go;

  assign early_go = EARLY_EN && early_rise;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q + 1'b1;
    defer_d = defer_q;
    unique case (st_q)
      SQ_IDLE: begin
        cnt_d   = '0;
        defer_d = 1'b0;
        if (trig) st_d = SQ_DELAY;
      end
      SQ_DELAY: begin
        if (hold_req) defer_d = 1'b1;
        if (cnt_q == DLY_LAST) begin
          cnt_d = '0;
          st_d  = (defer_q || hold_req) ? SQ_WAIT : SQ_GUARD;
        end
      end
      SQ_WAIT: begin
        cnt_d = '0;
        if (!hold_req || early_go) st_d = SQ_RST;
      end
      SQ_GUARD: begin
        cnt_d = '0;
        st_d  = SQ_RST;
      end
      SQ_RST: begin
        if (cnt_q == RST_LAST) begin
          cnt_d = '0;
          st_d  = SQ_EXT;
        end
      end
      SQ_EXT: begin
        if (cnt_q == EXT_LAST) begin
          cnt_d = '0;
          st_d  = SQ_IDLE;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= SQ_IDLE;
      cnt_q     <= '0;
      defer_q   <= 1'b0;
      det_reset <= 1'b0;
      det_hold  <= 1'b0;
      busy      <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      defer_q   <= defer_d;
      det_reset <= (st_d == SQ_RST);
      det_hold  <= (st_d != SQ_IDLE) && (st_d != SQ_DELAY);
      busy      <= (st_d != SQ_IDLE);
    end
  end

endmodule

// File: rtl/pk_reset_seq.sv
module pk_reset_seq #(
  parameter int NUM_CH    = 5,
  parameter int CLK_MHZ   = 50,
  parameter int DELAY_CYC = 2 * CLK_MHZ,
  parameter int RESET_CYC = 6 * CLK_MHZ,
  parameter int EXT_CYC   = CLK_MHZ / 2,
  parameter int SYNC_STG  = 2,
  parameter bit EARLY_EN  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] chan_flag,
  input  logic              conv_hold,
  input  logic              conv_early,
  output logic              det_reset,
  output logic              det_hold,
  output logic              busy
);

  localparam int SW = NUM_CH + 2;

  logic [SW-1:0]     raw_in, syn_out;
  logic [NUM_CH-1:0] flag_s, flag_prev;
  logic              hold_s, early_s, early_prev;
  logic              any_fall, early_rise;

  assign raw_in = {conv_early, conv_hold, chan_flag};

  pkseq_sync #(.WIDTH(SW), .STAGES(SYNC_STG)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d_in (raw_in),
    .d_out(syn_out)
  );

  assign flag_s  = syn_out[NUM_CH-1:0];
  assign hold_s  = syn_out[NUM_CH];
  assign early_s = syn_out[NUM_CH+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_prev  <= '0;
      early_prev <= 1'b0;
    end else begin
      flag_prev  <= flag_s;
      early_prev <= early_s;
    end
  end

  assign any_fall   = |(flag_prev & ~flag_s);
  assign early_rise = early_s & ~early_prev;

  pkseq_ctrl #(
    .DELAY_CYC(DELAY_CYC),
    .RESET_CYC(RESET_CYC),
    .EXT_CYC  (EXT_CYC),
    .EARLY_EN (EARLY_EN)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .trig      (any_fall),
    .hold_req  (hold_s),
    .early_rise(early_rise),
    .det_reset (det_reset),
    .det_hold  (det_hold),
    .busy      (busy)
  );

endmodule

// File: rtl/pkseq_chk.sv
module pkseq_chk #(
  parameter int RESET_CYC = 300
) (
  input logic clk,
  input logic rst,
  input logic det_reset,
  input logic det_hold,
  input logic busy
);

  logic [31:0] rst_run;

  always_ff @(posedge clk) begin
    if (rst)            rst_run <= '0;
    else if (det_reset) rst_run <= rst_run + 1;
    else                rst_run <= '0;
  end

  // R4: reset only while held
  assert_reset_needs_hold_R4: assert property (@(posedge clk) disable iff (rst)
    det_reset |-> det_hold);

  // R2: hold already high in the cycle before reset starts
  assert_hold_leads_reset_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(det_reset) |-> $past(det_hold));

  // R4: hold still high when reset ends
  assert_hold_trails_reset_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(det_reset) && !$past(rst)) |-> det_hold);

  // R3: reset pulse width
  assert_reset_width_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(det_reset) && !$past(rst)) |-> (rst_run == RESET_CYC));

  // R9: hold only inside a busy sequence
  assert_hold_in_busy_R9: assert property (@(posedge clk) disable iff (rst)
    det_hold |-> busy);

  // R8: synchronous reset clears outputs
  assert_sync_clear_R8: assert property (@(posedge clk)
    rst |=> (!det_reset && !det_hold && !busy));

endmodule

bind pk_reset_seq pkseq_chk #(.RESET_CYC(RESET_CYC)) u_pkseq_chk (
  .clk      (clk),
  .rst      (rst),
  .det_reset(det_reset),
  .det_hold (det_hold),
  .busy     (busy)
);

// File: tb/test_pk_reset_seq.sv
module test_pk_reset_seq;

  localparam int NCH = 5;
  localparam int D   = 100;
  localparam int R   = 300;
  localparam int X   = 25;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] chan_flag = '1;
  logic           conv_hold = 1'b0;
  logic           conv_early = 1'b0;
  logic           det_reset, det_hold, busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pk_reset_seq #(
    .NUM_CH(NCH), .CLK_MHZ(50), .DELAY_CYC(D), .RESET_CYC(R),
    .EXT_CYC(X), .SYNC_STG(2), .EARLY_EN(1'b1)
  ) i_pk_reset_seq (
    .clk(clk), .rst(rst), .chan_flag(chan_flag), .conv_hold(conv_hold),
    .conv_early(conv_early), .det_reset(det_reset), .det_hold(det_hold), .busy(busy)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_rst_up(bit defer, bit early, int h_off, int e_at);
    if (!defer) return D + 4;
    if (early)  return e_at + 3;
    return h_off + 3;
  endfunction

  task automatic idle_cycles(int k, string req);
    int seen = 0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (busy || det_hold || det_reset) seen = 1;
    end
    chk(req, seen, 0);
  endtask

  task automatic run_seq(int ch, bit defer, int h_on, int h_off, bit early, int e_at,
                         int other, int other_at);
    int t_bu = -1, t_hu = -1, t_ru = -1, t_rd = -1, t_hd = -1, t_bd = -1;
    int viol = 0;
    bit pb = 0, ph = 0, pr = 0;
    int ru;
    @(negedge clk);
    chan_flag[ch] = 1'b0;
    for (int n = 1; n < 4000; n++) begin
      @(negedge clk);
      if (busy && !pb) t_bu = n;
      if (!busy && pb) t_bd = n;
      if (det_hold && !ph) t_hu = n;
      if (!det_hold && ph) t_hd = n;
      if (det_reset && !pr) t_ru = n;
      if (!det_reset && pr) t_rd = n;
      if (det_reset && !det_hold) viol = 1;
      pb = busy; ph = det_hold; pr = det_reset;
      if (defer && n == h_on) conv_hold = 1'b1;
      if (defer && !early && n == h_off) conv_hold = 1'b0;
      conv_early = (early && n == e_at);
      if (n == other_at) chan_flag[other] = 1'b0;
      if (t_bd >= 0) break;
    end
    ru = exp_rst_up(defer, early, h_off, e_at);
    chk("R1 busy rise", t_bu, 3);
    chk("R2 hold rise", t_hu, 3 + D);
    chk(defer ? (early ? "R6 early reset start" : "R5 deferred reset start")
              : "R2 reset start", t_ru, ru);
    chk("R3 reset width", t_rd - t_ru, R);
    chk("R4 hold extension", t_hd - t_rd, X);
    chk("R4 reset without hold", viol, 0);
    chk("R9 busy fall with hold", t_bd, t_hd);
    if (early) begin
      idle_cycles(8, "R6 idle with request high");
      conv_hold = 1'b0;
      idle_cycles(8, "R6 late request fall ignored");
    end
    idle_cycles(6, "R7 no rearm after idle");
    chan_flag = '1;
    idle_cycles(8, "R1 rising flags start nothing");
  endtask

  initial begin
    int ch, hon, hlen, ea;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R8 reset det_reset", det_reset, 0);
    chk("R8 reset det_hold", det_hold, 0);
    chk("R8 reset busy", busy, 0);
    rst = 1'b0;
    idle_cycles(6, "R1 idle after reset");

    // R9: hold request toggled while idle
    @(negedge clk); conv_hold = 1'b1;
    idle_cycles(20, "R9 idle hold request");
    conv_hold = 1'b0;
    idle_cycles(6, "R9 idle hold released");

    // Directed: plain, each channel edge
    run_seq(0, 0, 0, 0, 0, 0, 4, 40);
    run_seq(4, 0, 0, 0, 0, 0, 0, D + 50);
    // Directed: deferral at both ends of the delay window
    run_seq(2, 1, 4, 600, 0, 0, 3, 10);
    run_seq(1, 1, D, D + 300, 0, 0, 0, 2 * D);
    // Directed: early strobe
    run_seq(3, 1, 30, 0, 1, D + 80, 1, D + 20);

    // Random mix
    for (int it = 0; it < 12; it++) begin
      ch = $urandom_range(NCH - 1, 0);
      case ($urandom_range(2, 0))
        0: run_seq(ch, 0, 0, 0, 0, 0, (ch + 1) % NCH, $urandom_range(D + R, 5));
        1: begin
          hon  = $urandom_range(D - 5, 5);
          hlen = $urandom_range(700, D + 20);
          run_seq(ch, 1, hon, hon + hlen, 0, 0, (ch + 2) % NCH, $urandom_range(D, 5));
        end
        default: begin
          hon = $urandom_range(D - 5, 5);
          ea  = $urandom_range(D + 200, D + 10);
          run_seq(ch, 1, hon, 0, 1, ea, (ch + 3) % NCH, $urandom_range(D, 5));
        end
      endcase
    end

    // R8: synchronous reset in the middle of a reset pulse
    @(negedge clk); chan_flag[2] = 1'b0;
    repeat (D + 20) @(negedge clk);
    chk("R8 in reset pulse before clear", det_reset, 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R8 clear det_reset", det_reset, 0);
    chk("R8 clear det_hold", det_hold, 0);
    chk("R8 clear busy", busy, 0);
    rst = 1'b0;
    idle_cycles(10, "R8 idle after clear");
    chan_flag = '1;
    idle_cycles(6, "R8 idle after flags restored");

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule